// File: doc/BRIEF.md
# Temperature Conversion Scheduler

This block decides when a two-channel temperature converter runs. Each measurement cycle converts the on-die channel first and the external-diode channel second. Each result is written into its own 8-bit two's-complement value register at 1 °C per LSB, and each write comes with a one-cycle update strobe. A 3-bit rate code sets the spacing between cycles in free-running mode. Each step up in the code halves the spacing, so code 0 is the slowest rate and code 7 is the fastest. The spacing is counted in ticks of an external timebase.

Two standby sources stop the scheduler. The first is an active-low hardware pin. The second is a stop bit in the configuration register. Both sources abort a cycle that is in flight and discard its result. They differ in one respect. While only the stop bit holds the block in standby, a one-shot write runs a single full cycle and the block then falls back to idle. A low pin blocks every conversion, including one-shots. The converter is reached through a start pulse, a channel select, and a done handshake that carries the result. The open-sensor input is captured when a cycle begins and is published with the external-channel result.

Top module: `tsense_conv_sched`

## Requirements
- R1: After reset both value registers read 80h, `busy` is 0, and no update strobe or converter start is active.
- R2: A cycle starts the converter with `adc_sel`=0 (on-die). The next done pulse stores `adc_data` into `local_val` with a `local_upd` pulse. The converter is then restarted with `adc_sel`=1 (external), and the following done pulse stores into `remote_val` with a `remote_upd` pulse. The two strobes never coincide.
- R3: In run mode (`stby_n`=1 and `cfg_stop`=0), consecutive cycle starts are `SLOT_TICKS << (7 - rate_code)` ticks apart, provided a cycle is shorter than that spacing. On entry to run mode the first cycle starts at once: `adc_start` is high two clock edges after the entry condition is applied.
- R4: A change of `rate_code` does not alter the spacing already running. It applies from the next cycle start onward.
- R5: While `stby_n` is 0, no cycle starts, including on a one-shot write. A cycle in flight is aborted and writes no result, and `busy` is 0 on the next cycle.
- R6: Setting `cfg_stop` during a free-running cycle aborts it. The value registers keep their last contents and no update strobe is issued.
- R7: With `cfg_stop`=1 and `stby_n`=1, a `oneshot_wr` pulse runs exactly one full cycle and the block then stays idle with no further cycles.
- R8: A `oneshot_wr` pulse that arrives while `busy` is 1 is ignored and does not cause a second cycle.
- R9: `sensor_open` is sampled when a cycle starts and appears on `open_flag` with the `remote_upd` of that cycle. Later changes during the cycle do not affect it.
- R10: `busy` is 1 from the cycle after the start decision until the external result is stored, and it is 0 in the cycle that `remote_upd` is high.
- R11: A done pulse that arrives while no conversion is pending changes neither value register and issues no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase tick, one cycle wide |
| rate_code | input | RATE_W | Cycle-rate code, 0 slowest |
| stby_n | input | 1 | Hardware standby, active low |
| cfg_stop | input | 1 | Software standby bit |
| oneshot_wr | input | 1 | One-shot write strobe |
| adc_start | output | 1 | Converter start pulse |
| adc_sel | output | 1 | Channel under conversion, 0 on-die, 1 external |
| adc_done | input | 1 | Converter done pulse |
| adc_data | input | DATA_W | Converter result, valid with `adc_done` |
| sensor_open | input | 1 | External diode open-circuit indication |
| busy | output | 1 | Cycle in progress |
| local_val | output | DATA_W | On-die value register |
| remote_val | output | DATA_W | External value register |
| local_upd | output | 1 | On-die value written |
| remote_upd | output | 1 | External value written |
| open_flag | output | 1 | Open-sensor flag forwarded with the external result |

## Verification
The bench instantiates the block with `SLOT_TICKS`=1 and drives a tick every four clocks. With these values the slowest code spans 512 clocks and codes 5 and 3 span 16 and 64 clocks. The bench can therefore measure exact start-to-start spacings, including the one interval that carries the old rate after a code change, within a short run. A converter model with a three-cycle latency makes each cycle shorter than the spacings the bench measures. The same latency also leaves a window inside each channel's conversion where standby can be raised or an extra one-shot write can be issued.

// File: rtl/tsense_conv_sched.sv
module tsense_conv_sched #(
  parameter int SLOT_TICKS = 4,
  parameter int RATE_W     = 3,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate_code,
  input  logic              stby_n,
  input  logic              cfg_stop,
  input  logic              oneshot_wr,
  output logic              adc_start,
  output logic              adc_sel,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  input  logic              sensor_open,
  output logic              busy,
  output logic [DATA_W-1:0] local_val,
  output logic [DATA_W-1:0] remote_val,
  output logic              local_upd,
  output logic              remote_upd,
  output logic              open_flag
);
  localparam int MAX_PER = SLOT_TICKS << ((2 ** RATE_W) - 1);
  localparam int CNT_W   = $clog2(MAX_PER + 1);
  localparam logic [RATE_W-1:0] TOP_CODE = '1;
  localparam logic [DATA_W-1:0] COLD     = DATA_W'(1) << (DATA_W - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOC, S_REM} st_t;

  st_t              state;
  logic [CNT_W-1:0] cnt_q, per_q, per_next;
  logic             os_q, open_smp;

  wire run_mode = stby_n && !cfg_stop;
  wire idle     = (state == S_IDLE);
  wire abort    = !idle && (!stby_n || (cfg_stop && !os_q));
  wire run_go   = run_mode && idle && (cnt_q >= per_q);
  wire os_go    = stby_n && cfg_stop && idle && oneshot_wr;
  wire go       = run_go || os_go;

  assign per_next = CNT_W'(SLOT_TICKS) << (TOP_CODE - rate_code);
  assign busy     = !idle;
  assign adc_sel  = (state == S_REM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '1;
      per_q <= '0;
    end else if (go) begin
      cnt_q <= '0;
      per_q <= per_next;
    end else if (!run_mode) begin
      cnt_q <= '1;
    end else if (tick && cnt_q != '1) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      os_q       <= 1'b0;
      open_smp   <= 1'b0;
      open_flag  <= 1'b0;
      adc_start  <= 1'b0;
      local_upd  <= 1'b0;
      remote_upd <= 1'b0;
      local_val  <= COLD;
      remote_val <= COLD;
    end else begin
      adc_start  <= 1'b0;
      local_upd  <= 1'b0;
      remote_upd <= 1'b0;
      if (abort) begin
        state <= S_IDLE;
        os_q  <= 1'b0;
      end else begin
        case (state)
          S_IDLE: if (go) begin
            state     <= S_LOC;
            adc_start <= 1'b1;
            os_q      <= os_go;
            open_smp  <= sensor_open;
          end
          S_LOC: if (adc_done) begin
            local_val <= adc_data;
            local_upd <= 1'b1;
            adc_start <= 1'b1;
            state     <= S_REM;
          end
          S_REM: if (adc_done) begin
            remote_val <= adc_data;
            remote_upd <= 1'b1;
            open_flag  <= open_smp;
            os_q       <= 1'b0;
            state      <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  a_r5_pin_idles: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_n |=> !busy);
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(local_upd && remote_upd));
  a_r6_local_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(local_val) |-> local_upd);
  a_r6_remote_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(remote_val) |-> remote_upd);
  a_r10_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> busy);
  a_r10_remote_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    remote_upd |-> !busy);
endmodule

// File: tb/tsense_conv_sched_test.sv
module tsense_conv_sched_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] tdiv = 0;
  logic tick;
  logic [2:0] rate_code = 3'd5;
  logic stby_n = 0, cfg_stop = 0, oneshot_wr = 0, sensor_open = 0, spur = 0;
  logic adc_start, adc_sel, adc_done, adc_done_m = 0, busy;
  logic local_upd, remote_upd, open_flag, sel_m = 0;
  logic [7:0] adc_data = 0, local_val, remote_val, lval_m = 0, rval_m = 0;
  logic [2:0] dly = 0;
  int cyc = 0, last_t = 0, prev_t = 0, nloc = 0, nlu = 0, nru = 0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick = (tdiv == 2'd3);
  assign adc_done = adc_done_m | spur;

  tsense_conv_sched #(.SLOT_TICKS(1), .RATE_W(3), .DATA_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rate_code(rate_code),
    .stby_n(stby_n), .cfg_stop(cfg_stop), .oneshot_wr(oneshot_wr),
    .adc_start(adc_start), .adc_sel(adc_sel), .adc_done(adc_done),
    .adc_data(adc_data), .sensor_open(sensor_open), .busy(busy),
    .local_val(local_val), .remote_val(remote_val), .local_upd(local_upd),
    .remote_upd(remote_upd), .open_flag(open_flag));

  always @(posedge clk) begin
    adc_done_m <= 1'b0;
    if (!rst_n) dly <= 0;
    else if (adc_start) begin
      dly <= 3'd3;
      sel_m <= adc_sel;
    end else if (dly != 0) begin
      dly <= dly - 3'd1;
      if (dly == 3'd1) begin
        adc_done_m <= 1'b1;
        adc_data <= sel_m ? rval_m : lval_m;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (adc_start && !adc_sel) begin
      prev_t <= last_t;
      last_t <= cyc;
      nloc <= nloc + 1;
    end
    if (local_upd) nlu <= nlu + 1;
    if (remote_upd) nru <= nru + 1;
  end

  always @(posedge clk) if (cyc > 150000) begin
    errors++;
    $display("FAIL watchdog actual=%0d expected<=150000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_loc(string req);
    int target = nloc + 1;
    int t = 0;
    while (nloc < target && t < 3000) begin @(negedge clk); t++; end
    if (nloc < target) chk({req, " start timeout"}, 0, 1);
  endtask

  task automatic wait_ru(string req);
    int target = nru + 1;
    int t = 0;
    while (nru < target && t < 3000) begin @(negedge clk); t++; end
    if (nru < target) chk({req, " remote timeout"}, 0, 1);
  endtask

  task automatic t_reset_r1();
    step(3);
    chk("R1 local reset", local_val, 8'h80);
    chk("R1 remote reset", remote_val, 8'h80);
    rst_n = 1;
    step(4);
    chk("R1 busy idle", busy, 0);
    chk("R1 no strobe", local_upd | remote_upd | adc_start, 0);
    chk("R5 pin low holds local", local_val, 8'h80);
  endtask

  task automatic t_run_r2();
    int c0, lu0;
    lval_m = 8'h19; rval_m = 8'h4B; sensor_open = 0;
    rate_code = 3'd5; cfg_stop = 0;
    c0 = cyc; stby_n = 1;
    wait_loc("R3");
    chk("R3 immediate first start", last_t - c0, 1);
    lu0 = nlu;
    while (nlu == lu0) @(negedge clk);
    chk("R10 busy during cycle", busy, 1);
    chk("R2 local stored", local_val, 8'h19);
    chk("R2 remote not yet", nru, 0);
    wait_ru("R2");
    chk("R2 remote stored", remote_val, 8'h4B);
    chk("R10 idle at remote strobe", busy, 0);
    chk("R9 open clear", open_flag, 0);
  endtask

  task automatic t_rate_r3_r4();
    wait_loc("R3"); wait_loc("R3");
    chk("R3 code5 spacing", last_t - prev_t, 16);
    rate_code = 3'd3;
    wait_loc("R4");
    chk("R4 old spacing kept", last_t - prev_t, 16);
    wait_loc("R3");
    chk("R3 code3 spacing", last_t - prev_t, 64);
    rate_code = 3'd0;
    wait_loc("R4");
    chk("R4 old spacing kept code0", last_t - prev_t, 64);
    wait_loc("R3");
    chk("R3 code0 spacing", last_t - prev_t, 512);
  endtask

  task automatic t_sw_abort_r6();
    int lu0 = nlu, ru0 = nru;
    lval_m = 8'h32;
    cfg_stop = 1;
    step(40);
    chk("R6 busy cleared", busy, 0);
    chk("R6 local kept", local_val, 8'h19);
    chk("R6 no strobe", (nlu - lu0) + (nru - ru0), 0);
  endtask

  task automatic t_oneshot_r7_r8_r9();
    int l0 = nloc, lu0 = nlu, ru0 = nru;
    lval_m = 8'h0A; rval_m = 8'h64; sensor_open = 1;
    oneshot_wr = 1; step(1); oneshot_wr = 0;
    step(2);
    sensor_open = 0;
    oneshot_wr = 1; step(1); oneshot_wr = 0;
    step(40);
    chk("R7 local one-shot", local_val, 8'h0A);
    chk("R7 remote one-shot", remote_val, 8'h64);
    chk("R9 open sampled at start", open_flag, 1);
    chk("R8 single cycle", nloc - l0, 1);
    chk("R7 one pair of strobes", (nlu - lu0) + (nru - ru0), 2);
    step(1200);
    chk("R7 stays idle", nloc - l0, 1);
    chk("R7 busy low", busy, 0);
  endtask

  task automatic t_pin_block_r5();
    int l0 = nloc;
    stby_n = 0;
    step(2);
    oneshot_wr = 1; step(1); oneshot_wr = 0;
    cfg_stop = 0;
    step(1200);
    chk("R5 pin blocks all starts", nloc - l0, 0);
    chk("R5 busy low", busy, 0);
  endtask

  task automatic t_pin_abort_r5();
    int c0, lu0, ru0;
    lval_m = 8'h7F; rval_m = 8'h05;
    c0 = cyc; stby_n = 1;
    wait_loc("R3");
    chk("R3 immediate after pin release", last_t - c0, 1);
    lu0 = nlu;
    while (nlu == lu0) @(negedge clk);
    ru0 = nru;
    stby_n = 0;
    step(1);
    chk("R5 aborted busy", busy, 0);
    step(20);
    chk("R5 local written", local_val, 8'h7F);
    chk("R5 remote kept", remote_val, 8'h64);
    chk("R5 no remote strobe", nru - ru0, 0);
  endtask

  task automatic t_spur_r11();
    int lu0 = nlu, ru0 = nru;
    spur = 1; step(1); spur = 0;
    step(3);
    chk("R11 local unchanged", local_val, 8'h7F);
    chk("R11 remote unchanged", remote_val, 8'h64);
    chk("R11 no strobe", (nlu - lu0) + (nru - ru0), 0);
  endtask

  initial begin
    t_reset_r1();
    t_run_r2();
    t_rate_r3_r4();
    t_sw_abort_r6();
    t_oneshot_r7_r8_r9();
    t_pin_block_r5();
    t_pin_abort_r5();
    t_spur_r11();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule